// File: doc/BRIEF.md
# Serial EEPROM Byte Access Controller

This block sits between a host and a byte-wide serial EEPROM on an SPI bus. The host issues single requests, and the controller turns each one into the serial frames the memory expects. The supported requests are: read one byte, write one byte, set the write latch, and clear the write latch. The controller drives chip select, the serial clock and the serial data out. It samples the serial data in, and it ends each request with a one-cycle completion pulse. For a read, that pulse carries the byte returned by the memory.

A host write never reaches the bus as a single frame. The controller first sends a frame that sets the memory's write latch. It then sends the data frame and waits a host-chosen number of cycles for the internal programming. Last, it sends a frame that clears the latch again. Each frame has its own chip-select assertion. A read is one frame, and a blank byte at its end clocks the stored data back.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the completion pulse, so the host must hold its request until it is taken. A request presented while the block is busy is not taken and has no effect. The completion side has no back-pressure: `done` and `rd_data` are presented for a single cycle, and the host must capture them then.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: A read request (`req_op` = 0) produces one chip-select frame of three bytes: 0x03, the address byte, then 0x00. The byte shifted in on `miso` during the third byte is presented on `rd_data` with `done`.
- R2: A write request (`req_op` = 1) produces three separate frames in this order: {0x06}, then {0x02, address, data}, then {0x04}. Chip select goes high between these frames.
- R3: Between the end of the data frame of a write and the start of its latch-clear frame, chip select stays high for at least 2·H + `wr_wait` system clocks.
- R4: The bus runs in SPI mode 0 and sends the most significant bit first. `sck` is low whenever `cs_n` is high. `mosi` changes only while `sck` is low.
- R5: Each `sck` high phase lasts exactly H system clocks, where H = `clk_div` when `clk_div` ≥ 2, and H = 2 otherwise.
- R6: After every frame, chip select stays high for at least 2·H system clocks (one full serial clock period) before the next frame or before `done`.
- R7: `req_ready` is high exactly when `busy` is low. `busy` rises on the cycle after a request is accepted. A request presented while busy produces no frame and no completion.
- R8: `done` is a single-cycle pulse, one per accepted request. `busy` is low in the same cycle as `done`.
- R9: The address field `req_addr` is 7 bits wide (0 to 127). The most significant bit of the address byte on the bus is always 0.
- R10: A latch-set request (`req_op` = 2) produces the single frame {0x06}. A latch-clear request (`req_op` = 3) produces the single frame {0x04}.
- R11: While reset is held and directly after it, `cs_n` is high, `sck` is low, `busy` and `done` are low, and `req_ready` is high.
- R12: `clk_div` and `wr_wait` are captured when a request is accepted. Changing them while busy does not alter the running request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_op | input | 2 | 0 read, 1 write, 2 set latch, 3 clear latch |
| req_addr | input | 7 | Byte address |
| req_wdata | input | 8 | Byte to write |
| clk_div | input | DIV_W (8) | Serial clock half-period in system clocks |
| wr_wait | input | WAIT_W (16) | Programming wait after a data frame, in system clocks |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by a read, valid with `done` |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to memory |
| miso | input | 1 | Serial data from memory |

## Verification
A wrong frame step or a wrong sequencer step shows on the bus within one frame. Either the byte pattern decoded between a chip-select fall and rise differs from the frame the model expects, or a frame appears when none is pending. A wrong half-period count shows at the first high phase of `sck`, within H clocks. A stuck busy or completion state shows on the very cycle `busy` or `done` disagrees with the model, which tracks acceptance and completion on every clock. Read data is returned by a memory model in the bench, so a bit-order or sampling-edge error shows as a wrong `rd_data` at the first read.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned FRAME_MAXB = 3;
  localparam int unsigned FRAME_W    = FRAME_MAXB * BYTE_W;

  localparam logic [7:0] INS_READ  = 8'h03;
  localparam logic [7:0] INS_WRITE = 8'h02;
  localparam logic [7:0] INS_WREN  = 8'h06;
  localparam logic [7:0] INS_WRDI  = 8'h04;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WREN  = 2'd2,
    OP_WRDI  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    E_IDLE, E_SETUP, E_LO, E_HI, E_TAIL, E_GAP
  } eng_state_e;

  typedef enum logic [1:0] {
    S_IDLE, S_FRAME, S_HOLD
  } seq_state_e;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;   // left aligned, first byte in the top bits
    logic [1:0]         nbytes;
  } frame_t;

  function automatic frame_t build_frame(op_e kind, logic [7:0] addr, logic [7:0] data);
    frame_t f;
    f.bits   = '0;
    f.nbytes = 2'd1;
    case (kind)
      OP_READ:  begin f.bits = {INS_READ, addr, 8'h00}; f.nbytes = 2'd3; end
      OP_WRITE: begin f.bits = {INS_WRITE, addr, data}; f.nbytes = 2'd3; end
      OP_WREN:  f.bits = {INS_WREN, 16'h0000};
      default:  f.bits = {INS_WRDI, 16'h0000};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/spi_eeprom_frame_engine.sv
module spi_eeprom_frame_engine
  import spi_eeprom_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  frame_t           frame,
  input  logic [DIV_W-1:0] half,
  output logic             cs_n,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [7:0]       rx_byte,
  output logic             fin
);
  localparam int unsigned CNT_W  = DIV_W + 1;
  localparam int unsigned BITS_W = $clog2(FRAME_W + 1);

  eng_state_e          st;
  logic [CNT_W-1:0]    cnt;
  logic [BITS_W-1:0]   bits_left;
  logic [FRAME_W-1:0]  shreg;
  logic [CNT_W-1:0]    half_m1;
  logic [CNT_W-1:0]    period_m1;
  logic                expire;

  assign half_m1   = {1'b0, half} - CNT_W'(1);
  assign period_m1 = {half, 1'b0} - CNT_W'(1);
  assign expire    = (cnt == '0);
  assign mosi      = ~cs_n & shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      cnt       <= '0;
      bits_left <= '0;
      shreg     <= '0;
      cs_n      <= 1'b1;
      sck       <= 1'b0;
      rx_byte   <= '0;
      fin       <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!expire && st != E_IDLE) cnt <= cnt - CNT_W'(1);
      case (st)
        E_IDLE: if (start) begin
          shreg     <= frame.bits;
          bits_left <= BITS_W'({frame.nbytes, 3'b000});
          cs_n      <= 1'b0;
          cnt       <= half_m1;
          st        <= E_SETUP;
        end
        E_SETUP: if (expire) begin
          cnt <= half_m1;
          st  <= E_LO;
        end
        E_LO: if (expire) begin
          sck     <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
          cnt     <= half_m1;
          st      <= E_HI;
        end
        E_HI: if (expire) begin
          sck       <= 1'b0;
          shreg     <= {shreg[FRAME_W-2:0], 1'b0};
          bits_left <= bits_left - BITS_W'(1);
          cnt       <= half_m1;
          st        <= (bits_left == BITS_W'(1)) ? E_TAIL : E_LO;
        end
        E_TAIL: if (expire) begin
          cs_n <= 1'b1;
          cnt  <= period_m1;
          st   <= E_GAP;
        end
        E_GAP: if (expire) begin
          fin <= 1'b1;
          st  <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_eeprom_sequencer.sv
module spi_eeprom_sequencer
  import spi_eeprom_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  input  logic [DIV_W-1:0]  half_in,
  input  logic [WAIT_W-1:0] wr_wait,
  input  logic              fin,
  input  logic [7:0]        rx_byte,
  output logic              start,
  output frame_t            frame,
  output logic [DIV_W-1:0]  half,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data
);
  seq_state_e        st;
  op_e               op_q;
  op_e               kind;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] wcnt;
  logic [1:0]        step;
  logic              accept;
  logic              is_write;

  assign busy     = (st != S_IDLE);
  assign accept   = req_valid && !busy;
  assign is_write = (op_q == OP_WRITE);

  always_comb begin
    kind = op_q;
    if (is_write) begin
      case (step)
        2'd0:    kind = OP_WREN;
        2'd1:    kind = OP_WRITE;
        default: kind = OP_WRDI;
      endcase
    end
  end

  assign frame = build_frame(kind, {{(8-ADDR_W){1'b0}}, addr_q}, data_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      data_q  <= '0;
      wait_q  <= '0;
      wcnt    <= '0;
      half    <= DIV_W'(2);
      step    <= '0;
      start   <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      start <= 1'b0;
      done  <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          op_q   <= op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_wdata;
          wait_q <= wr_wait;
          half   <= half_in;
          step   <= 2'd0;
          start  <= 1'b1;
          st     <= S_FRAME;
        end
        S_FRAME: if (fin) begin
          if (is_write && step == 2'd0) begin
            step  <= 2'd1;
            start <= 1'b1;
          end else if (is_write && step == 2'd1) begin
            step <= 2'd2;
            if (wait_q == '0) begin
              start <= 1'b1;
            end else begin
              wcnt <= wait_q;
              st   <= S_HOLD;
            end
          end else begin
            done <= 1'b1;
            if (op_q == OP_READ) rd_data <= rx_byte;
            st <= S_IDLE;
          end
        end
        S_HOLD: begin
          wcnt <= wcnt - WAIT_W'(1);
          if (wcnt == WAIT_W'(1)) begin
            start <= 1'b1;
            st    <= S_FRAME;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [WAIT_W-1:0] wr_wait,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

  logic [DIV_W-1:0] half_in;
  logic [DIV_W-1:0] half;
  logic             start;
  logic             fin;
  logic [7:0]       rx_byte;
  frame_t           frame;

  assign half_in   = (clk_div < MIN_HALF) ? MIN_HALF : clk_div;
  assign req_ready = ~busy;

  spi_eeprom_sequencer #(.DIV_W(DIV_W), .WAIT_W(WAIT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .half_in   (half_in),
    .wr_wait   (wr_wait),
    .fin       (fin),
    .rx_byte   (rx_byte),
    .start     (start),
    .frame     (frame),
    .half      (half),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data)
  );

  spi_eeprom_frame_engine #(.DIV_W(DIV_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .frame   (frame),
    .half    (half),
    .cs_n    (cs_n),
    .sck     (sck),
    .mosi    (mosi),
    .miso    (miso),
    .rx_byte (rx_byte),
    .fin     (fin)
  );
endmodule

// File: rtl/spi_eeprom_ctrl_chk.sv
module spi_eeprom_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sck,
  input logic mosi
);
  // R4
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R7
  select_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind spi_eeprom_ctrl spi_eeprom_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .cs_n      (cs_n),
  .sck       (sck),
  .mosi      (mosi)
);

// File: tb/tb_spi_eeprom_ctrl.sv
module tb_spi_eeprom_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [6:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  clk_div = 8'd2;
  logic [15:0] wr_wait = '0;
  logic        busy, done, cs_n, sck, mosi;
  logic        miso = 1'b0;
  logic [7:0]  rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .clk_div(clk_div), .wr_wait(wr_wait), .busy(busy), .done(done),
    .rd_data(rd_data), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  typedef struct { int n; logic [23:0] bits; int h; int extra; } fr_t;
  typedef struct { int op; logic [7:0] d; } rs_t;

  fr_t  fq[$];
  rs_t  rq[$];
  int   vectors = 0;
  int   fails = 0;
  int   cyc = 0;
  bit   model_busy = 0;
  bit   finished = 0;
  logic [7:0] exp_mem [128];
  logic [7:0] eep_mem [128];
  bit   eep_we = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // bus monitor and memory model, sampled on the falling edge
  bit          prev_cs = 1, prev_sck = 0, have_cur = 0, have_prev = 0, rd_flag = 0;
  int          bitcnt = 0, hi_len = 0, rise_cyc = 0, prev_h = 0, prev_extra = 0;
  logic [23:0] cap = '0;
  logic [6:0]  rd_addr = '0;
  fr_t         cur;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      if (cyc > WATCHDOG) begin
        chk(0, "WDOG", "watchdog expired", cyc, WATCHDOG);
        finish_run();
      end
      // completion and busy tracking (R7, R8)
      if (done) begin
        chk(model_busy, "R8", "done without pending request", 1, 0);
        if (rq.size() > 0) begin
          if (rq[0].op == 0) chk(rd_data == rq[0].d, "R1", "read data", rd_data, rq[0].d);
          void'(rq.pop_front());
        end else chk(0, "R8", "extra done", 1, 0);
        model_busy = 0;
      end
      chk(busy == model_busy, "R7", "busy vs model", busy, model_busy);
      chk(req_ready == !model_busy, "R7", "ready vs model", req_ready, !model_busy);
      chk(!(cs_n && sck), "R4", "sck high while deselected", sck, 0);
      // frame start
      if (prev_cs && !cs_n) begin
        bitcnt = 0; cap = '0; rd_flag = 0;
        if (have_prev)
          chk((cyc - rise_cyc) >= 2*prev_h + prev_extra, "R3/R6", "deselect gap",
              cyc - rise_cyc, 2*prev_h + prev_extra);
        if (fq.size() > 0) begin cur = fq.pop_front(); have_cur = 1; end
        else begin chk(0, "R7", "unexpected frame", 1, 0); have_cur = 0; end
      end
      // sck edges
      if (!cs_n && !prev_sck && sck) begin
        cap = {cap[22:0], mosi};
        bitcnt++;
        hi_len = 1;
        if (bitcnt == 16 && cap[15:8] == 8'h03) begin rd_flag = 1; rd_addr = cap[6:0]; end
      end else if (sck) hi_len++;
      if (prev_sck && !sck && have_cur)
        chk(hi_len == cur.h, "R5/R12", "sck high phase", hi_len, cur.h);
      // frame end
      if (!prev_cs && cs_n) begin
        rise_cyc = cyc;
        if (have_cur) begin
          chk(bitcnt == cur.n*8, "R1/R2/R10", "frame bit count", bitcnt, cur.n*8);
          chk(cap == (cur.bits >> (24 - cur.n*8)), "R1/R2/R10", "frame bytes",
              cap, cur.bits >> (24 - cur.n*8));
          if (cur.n == 3) chk(cap[15] == 1'b0, "R9", "address msb", cap[15], 0);
          if (bitcnt == 8 && cap[7:0] == 8'h06) eep_we = 1;
          if (bitcnt == 8 && cap[7:0] == 8'h04) eep_we = 0;
          if (bitcnt == 24 && cap[23:16] == 8'h02) begin
            chk(eep_we, "R2", "write latch set before data frame", eep_we, 1);
            if (eep_we) eep_mem[cap[14:8]] = cap[7:0];
          end
          prev_h = cur.h; prev_extra = cur.extra; have_prev = 1;
        end
        have_cur = 0;
      end
      miso = (rd_flag && bitcnt >= 16 && bitcnt < 24) ? eep_mem[rd_addr][23 - bitcnt] : 1'b0;
      prev_cs = cs_n; prev_sck = sck;
    end
  end

  task automatic send(int op, logic [6:0] a, logic [7:0] d, logic [7:0] div, logic [15:0] ww);
    int h;
    fr_t f;
    h = (div < 2) ? 2 : div;
    @(negedge clk);
    req_valid = 1; req_op = op[1:0]; req_addr = a; req_wdata = d;
    clk_div = div; wr_wait = ww;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    model_busy = 1;
    case (op)
      0: begin
        f = '{3, {8'h03, 1'b0, a, 8'h00}, h, 0}; fq.push_back(f);
        rq.push_back('{0, exp_mem[a]});
      end
      1: begin
        f = '{1, {8'h06, 16'h0}, h, 0}; fq.push_back(f);
        f = '{3, {8'h02, 1'b0, a, d}, h, int'(ww)}; fq.push_back(f);
        f = '{1, {8'h04, 16'h0}, h, 0}; fq.push_back(f);
        exp_mem[a] = d;
        rq.push_back('{1, 8'h00});
      end
      2: begin f = '{1, {8'h06, 16'h0}, h, 0}; fq.push_back(f); rq.push_back('{2, 8'h00}); end
      default: begin f = '{1, {8'h04, 16'h0}, h, 0}; fq.push_back(f); rq.push_back('{3, 8'h00}); end
    endcase
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (model_busy);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin exp_mem[i] = 8'h00; eep_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R11: reset state while held
    chk(cs_n == 1 && sck == 0 && busy == 0 && done == 0, "R11", "outputs in reset",
        {cs_n, sck, busy, done}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && cs_n == 1, "R11", "outputs after reset", {req_ready, cs_n}, 2'b11);

    // R10: stand-alone latch set
    send(2, 7'd0, 8'h00, 8'd2, 16'd0); wait_idle();
    // R2: write, no wait, then R1 read back
    send(1, 7'd5, 8'hA5, 8'd2, 16'd0); wait_idle();
    send(0, 7'd5, 8'h00, 8'd3, 16'd0); wait_idle();
    // R3 and R9: top address with a programming wait
    send(1, 7'd127, 8'h3C, 8'd4, 16'd40); wait_idle();
    send(0, 7'd127, 8'h00, 8'd2, 16'd0); wait_idle();
    // R5: divider below minimum clamps to 2
    send(1, 7'd0, 8'h81, 8'd0, 16'd3); wait_idle();
    send(0, 7'd0, 8'h00, 8'd1, 16'd0); wait_idle();
    // R10: stand-alone latch clear
    send(3, 7'd0, 8'h00, 8'd5, 16'd0); wait_idle();
    // R7 and R12: requests while busy are ignored, divider change has no effect
    send(0, 7'd5, 8'h00, 8'd3, 16'd0);
    for (int i = 0; i < 6; i++) begin
      req_valid = 1; req_op = 2'd1; req_addr = 7'd9; req_wdata = 8'hEE; clk_div = 8'd6;
      @(negedge clk);
    end
    req_valid = 0;
    wait_idle();
    chk(fq.size() == 0 && rq.size() == 0, "R7", "no work from ignored requests", fq.size(), 0);
    // back-to-back writes and reads of several bytes
    for (int i = 0; i < 9; i++) send(1, 7'(i), 8'(8'h11 * (i + 1)), 8'd2, 16'd5);
    for (int i = 0; i < 9; i++) send(0, 7'(i), 8'h00, 8'd2, 16'd0);
    wait_idle();
    chk(fq.size() == 0, "R2", "all frames observed", fq.size(), 0);
    chk(rq.size() == 0, "R8", "all completions observed", rq.size(), 0);
    finish_run();
  end
endmodule